// File: doc/BRIEF.md
# Remote Memory Access Request Validator

This block sits on the target side of a remote memory access path. Each incoming one-sided request carries an operation (read or write), a destination queue pair number, a sequence number, a remote virtual address, a remote key and a byte length. The validator checks the request against a small table of local queue pairs and a small table of registered memory regions. For each request it then hands one decision to the DMA engine: a grant that carries the operation, address and length, or a NAK with a 3-bit reason code. A rejected request never reaches memory. A granted write goes straight to the DMA engine, and no interrupt or notice goes to the local processor.

Both tables are loaded through plain write ports. A queue pair entry holds a queue pair number, an active flag and the next expected sequence number. A region entry holds a base address, a length, a key, read and write permission flags and a valid flag. The validator does not parse packets, translate addresses or move data.

Requests enter on a valid/ready stream and decisions leave on a second valid/ready stream. There is one output register. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or is being drained in the same cycle (`dec_ready` high), so the downstream stage applies back-pressure straight to the request side. A decision that is not taken stays on the outputs unchanged.

Top module: `rma_req_checker`

## Requirements
- R1: After reset `dec_valid` is 0 and `req_ready` is 1. No queue pair is active and no region is valid, so the first request gets a NAK with reason 1.
- R2: A request taken on edge T shows its decision with `dec_valid`=1 after edge T. While `dec_valid`=1 and `dec_ready`=0, `req_ready` is 0 and every decision output holds its value. With no request taken, `dec_valid` drops once the decision is consumed.
- R3: If `req_qpn` matches no active queue pair entry, the result is a NAK with reason 1. An entry written with its active flag at 0 stops matching.
- R4: If `req_psn` differs from the matched entry's expected sequence number, the result is a NAK with reason 2. The expected number is loaded by a queue pair write. It advances by one, modulo 2^PSN_W, only when the request is granted. Each queue pair keeps its own count.
- R5: If `req_rkey` matches no valid region's key, the result is a NAK with reason 3.
- R6: The request must satisfy `req_vaddr >= base` and `req_vaddr + req_len <= base + length`, where the sums are computed without wraparound. Otherwise the result is a NAK with reason 4. A request that exactly fills the region is granted.
- R7: If `req_vaddr + req_len` goes past 2^ADDR_W, the result is a NAK with reason 4. A range that ends exactly at 2^ADDR_W is allowed.
- R8: `req_op`=0 is a write and needs the region's write flag. `req_op`=1 is a read and needs the read flag. A missing flag gives a NAK with reason 5.
- R9: The checks are evaluated in the order queue pair (1), sequence (2), key (3), bounds (4), permission (5). The NAK reports the first check that fails.
- R10: A grant has `dec_grant`=1 and `dec_reason`=0, and it carries the request's op, address and length. A NAK has `dec_grant`=0, meaning no memory access, and a nonzero reason.
- R11: Writing a region slot with its valid flag at 0 removes that slot, and its key then gets reason 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qp_cfg_we | input | 1 | Write strobe for the queue pair table |
| qp_cfg_idx | input | QP_IDX_W | Queue pair slot to write |
| qp_cfg_qpn | input | QPN_W | Queue pair number for the slot |
| qp_cfg_psn | input | PSN_W | Initial expected sequence number |
| qp_cfg_active | input | 1 | Slot active flag |
| mr_cfg_we | input | 1 | Write strobe for the region table |
| mr_cfg_idx | input | MR_IDX_W | Region slot to write |
| mr_cfg_base | input | ADDR_W | Region base address |
| mr_cfg_len | input | LEN_W | Region length in bytes |
| mr_cfg_key | input | KEY_W | Region key |
| mr_cfg_rd | input | 1 | Remote read allowed |
| mr_cfg_wr | input | 1 | Remote write allowed |
| mr_cfg_valid | input | 1 | Region slot valid |
| req_valid | input | 1 | Request header valid |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 1 | 0 = write, 1 = read |
| req_qpn | input | QPN_W | Destination queue pair number |
| req_psn | input | PSN_W | Request sequence number |
| req_vaddr | input | ADDR_W | Remote virtual address |
| req_rkey | input | KEY_W | Remote key |
| req_len | input | LEN_W | Transfer length in bytes |
| dec_valid | output | 1 | Decision valid |
| dec_ready | input | 1 | DMA side takes the decision |
| dec_grant | output | 1 | 1 = grant, 0 = NAK |
| dec_reason | output | 3 | 0 ok, 1 queue pair, 2 sequence, 3 key, 4 bounds, 5 permission |
| dec_op | output | 1 | Granted operation |
| dec_vaddr | output | ADDR_W | Granted address |
| dec_len | output | LEN_W | Granted length |

## Verification
Each decision appears on the outputs one cycle after the edge that takes its request. It is consumed on the first later edge where `dec_ready` is high. The scoreboard monitor compares at the falling edge of any cycle in which `dec_valid` and `dec_ready` are both high, so each queued expectation is matched to exactly the decision that will transfer on the next edge. The stall case holds `dec_ready` low and samples one nanosecond after each rising edge. It checks that the decision is present in the cycle right after acceptance, that it does not change for three more cycles, and that `req_ready` stays low during that time. Table writes are issued only after the previous decision has been registered, so the expected sequence numbers never depend on races.

// File: rtl/rmv_pkg.sv
package rmv_pkg;
  typedef enum logic [2:0] {
    RSN_OK    = 3'd0,
    RSN_QP    = 3'd1,
    RSN_SEQ   = 3'd2,
    RSN_KEY   = 3'd3,
    RSN_RANGE = 3'd4,
    RSN_PERM  = 3'd5
  } reason_e;

  localparam logic OP_WRITE = 1'b0;
  localparam logic OP_READ  = 1'b1;
endpackage

// File: rtl/rmv_qp_table.sv
module rmv_qp_table #(
  parameter int NUM_QP = 4,
  parameter int QPN_W  = 8,
  parameter int PSN_W  = 8,
  localparam int IDX_W = (NUM_QP > 1) ? $clog2(NUM_QP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [QPN_W-1:0] cfg_qpn,
  input  logic [PSN_W-1:0] cfg_psn,
  input  logic             cfg_active,
  input  logic [QPN_W-1:0] look_qpn,
  input  logic [PSN_W-1:0] look_psn,
  input  logic             adv,
  output logic             qp_hit,
  output logic             psn_ok
);
  logic [NUM_QP-1:0] match;
  logic [NUM_QP-1:0] seq_eq;
  logic [NUM_QP-1:0] sel;

  // first matching slot wins
  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_QP; i++) begin
      if (match[i] && (sel == '0)) sel[i] = 1'b1;
    end
  end

  assign qp_hit = |match;
  assign psn_ok = |(sel & seq_eq);

  generate
    for (genvar i = 0; i < NUM_QP; i++) begin : g_qp
      logic             act_q;
      logic [QPN_W-1:0] qpn_q;
      logic [PSN_W-1:0] exp_q;

      assign match[i]  = act_q && (qpn_q == look_qpn);
      assign seq_eq[i] = (exp_q == look_psn);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          act_q <= 1'b0;
          qpn_q <= '0;
          exp_q <= '0;
        end else if (cfg_we && (cfg_idx == IDX_W'(i))) begin
          act_q <= cfg_active;
          qpn_q <= cfg_qpn;
          exp_q <= cfg_psn;
        end else if (adv && sel[i]) begin
          exp_q <= exp_q + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/rmv_region_table.sv
module rmv_region_table #(
  parameter int NUM_REG = 4,
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int KEY_W   = 16,
  localparam int IDX_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1,
  localparam int EXT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [KEY_W-1:0]  cfg_key,
  input  logic              cfg_rd,
  input  logic              cfg_wr,
  input  logic              cfg_valid,
  input  logic [KEY_W-1:0]  look_key,
  input  logic [ADDR_W-1:0] look_vaddr,
  input  logic [LEN_W-1:0]  look_len,
  input  logic              look_op,
  output logic              key_hit,
  output logic              range_ok,
  output logic              perm_ok
);
  import rmv_pkg::*;

  localparam logic [EXT_W-1:0] SPACE_TOP = EXT_W'(1) << ADDR_W;

  logic [NUM_REG-1:0] key_eq;
  logic [NUM_REG-1:0] in_range;
  logic [NUM_REG-1:0] allowed;
  logic [NUM_REG-1:0] sel;
  logic [EXT_W-1:0]   req_end;
  logic               wraps;

  assign req_end = {1'b0, look_vaddr} + EXT_W'(look_len);
  assign wraps   = req_end > SPACE_TOP;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_REG; i++) begin
      if (key_eq[i] && (sel == '0)) sel[i] = 1'b1;
    end
  end

  assign key_hit  = |key_eq;
  assign range_ok = |(sel & in_range);
  assign perm_ok  = |(sel & allowed);

  generate
    for (genvar i = 0; i < NUM_REG; i++) begin : g_mr
      logic              vld_q;
      logic [ADDR_W-1:0] base_q;
      logic [LEN_W-1:0]  len_q;
      logic [KEY_W-1:0]  key_q;
      logic              rd_q;
      logic              wr_q;
      logic [EXT_W-1:0]  reg_end;

      assign reg_end     = {1'b0, base_q} + EXT_W'(len_q);
      assign key_eq[i]   = vld_q && (key_q == look_key);
      assign in_range[i] = !wraps && (look_vaddr >= base_q) && (req_end <= reg_end);
      assign allowed[i]  = (look_op == OP_READ) ? rd_q : wr_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q  <= 1'b0;
          base_q <= '0;
          len_q  <= '0;
          key_q  <= '0;
          rd_q   <= 1'b0;
          wr_q   <= 1'b0;
        end else if (cfg_we && (cfg_idx == IDX_W'(i))) begin
          vld_q  <= cfg_valid;
          base_q <= cfg_base;
          len_q  <= cfg_len;
          key_q  <= cfg_key;
          rd_q   <= cfg_rd;
          wr_q   <= cfg_wr;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/rma_req_checker.sv
module rma_req_checker #(
  parameter int NUM_QP  = 4,
  parameter int NUM_REG = 4,
  parameter int QPN_W   = 8,
  parameter int PSN_W   = 8,
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int KEY_W   = 16,
  localparam int QP_IDX_W = (NUM_QP > 1) ? $clog2(NUM_QP) : 1,
  localparam int MR_IDX_W = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                qp_cfg_we,
  input  logic [QP_IDX_W-1:0] qp_cfg_idx,
  input  logic [QPN_W-1:0]    qp_cfg_qpn,
  input  logic [PSN_W-1:0]    qp_cfg_psn,
  input  logic                qp_cfg_active,
  input  logic                mr_cfg_we,
  input  logic [MR_IDX_W-1:0] mr_cfg_idx,
  input  logic [ADDR_W-1:0]   mr_cfg_base,
  input  logic [LEN_W-1:0]    mr_cfg_len,
  input  logic [KEY_W-1:0]    mr_cfg_key,
  input  logic                mr_cfg_rd,
  input  logic                mr_cfg_wr,
  input  logic                mr_cfg_valid,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_op,
  input  logic [QPN_W-1:0]    req_qpn,
  input  logic [PSN_W-1:0]    req_psn,
  input  logic [ADDR_W-1:0]   req_vaddr,
  input  logic [KEY_W-1:0]    req_rkey,
  input  logic [LEN_W-1:0]    req_len,
  output logic                dec_valid,
  input  logic                dec_ready,
  output logic                dec_grant,
  output logic [2:0]          dec_reason,
  output logic                dec_op,
  output logic [ADDR_W-1:0]   dec_vaddr,
  output logic [LEN_W-1:0]    dec_len
);
  import rmv_pkg::*;

  logic    qp_hit, psn_ok, key_hit, range_ok, perm_ok;
  logic    take, grant_d;
  reason_e why_d, why_q;

  assign req_ready = !dec_valid || dec_ready;
  assign take      = req_valid && req_ready;

  rmv_qp_table #(
    .NUM_QP(NUM_QP), .QPN_W(QPN_W), .PSN_W(PSN_W)
  ) u_qp (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(qp_cfg_we), .cfg_idx(qp_cfg_idx), .cfg_qpn(qp_cfg_qpn),
    .cfg_psn(qp_cfg_psn), .cfg_active(qp_cfg_active),
    .look_qpn(req_qpn), .look_psn(req_psn), .adv(take && grant_d),
    .qp_hit(qp_hit), .psn_ok(psn_ok)
  );

  rmv_region_table #(
    .NUM_REG(NUM_REG), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .KEY_W(KEY_W)
  ) u_mr (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(mr_cfg_we), .cfg_idx(mr_cfg_idx), .cfg_base(mr_cfg_base),
    .cfg_len(mr_cfg_len), .cfg_key(mr_cfg_key), .cfg_rd(mr_cfg_rd),
    .cfg_wr(mr_cfg_wr), .cfg_valid(mr_cfg_valid),
    .look_key(req_rkey), .look_vaddr(req_vaddr), .look_len(req_len),
    .look_op(req_op),
    .key_hit(key_hit), .range_ok(range_ok), .perm_ok(perm_ok)
  );

  // fixed check order; the first failure is reported
  always_comb begin
    if (!qp_hit)        why_d = RSN_QP;
    else if (!psn_ok)   why_d = RSN_SEQ;
    else if (!key_hit)  why_d = RSN_KEY;
    else if (!range_ok) why_d = RSN_RANGE;
    else if (!perm_ok)  why_d = RSN_PERM;
    else                why_d = RSN_OK;
  end
  assign grant_d = (why_d == RSN_OK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_grant <= 1'b0;
      why_q     <= RSN_OK;
      dec_op    <= 1'b0;
      dec_vaddr <= '0;
      dec_len   <= '0;
    end else if (take) begin
      dec_valid <= 1'b1;
      dec_grant <= grant_d;
      why_q     <= why_d;
      dec_op    <= req_op;
      dec_vaddr <= req_vaddr;
      dec_len   <= req_len;
    end else if (dec_ready) begin
      dec_valid <= 1'b0;
    end
  end

  assign dec_reason = why_q;
endmodule

// File: rtl/rmv_checker.sv
module rmv_checker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  localparam int EXT_W = ADDR_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              dec_valid,
  input logic              dec_ready,
  input logic              dec_grant,
  input logic [2:0]        dec_reason,
  input logic              dec_op,
  input logic [ADDR_W-1:0] dec_vaddr,
  input logic [LEN_W-1:0]  dec_len
);
  AST_ACCEPT_GIVES_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> dec_valid); // R2

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_ready |=> dec_valid && $stable(dec_grant) && $stable(dec_reason)
      && $stable(dec_op) && $stable(dec_vaddr) && $stable(dec_len)); // R2

  AST_NO_SPURIOUS_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid && !(req_valid && req_ready) |=> !dec_valid); // R2

  AST_GRANT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_grant |-> dec_reason == 3'd0); // R10

  AST_NAK_CODED: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_grant |-> (dec_reason != 3'd0) && (dec_reason <= 3'd5)); // R9

  AST_GRANT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_grant |-> ({1'b0, dec_vaddr} + EXT_W'(dec_len)) <= (EXT_W'(1) << ADDR_W)); // R7
endmodule

bind rma_req_checker rmv_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_grant(dec_grant),
  .dec_reason(dec_reason), .dec_op(dec_op), .dec_vaddr(dec_vaddr), .dec_len(dec_len)
);

// File: tb/sim_rma_req_checker.sv
module sim_rma_req_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        qp_cfg_we = 1'b0;
  logic [1:0]  qp_cfg_idx = '0;
  logic [7:0]  qp_cfg_qpn = '0;
  logic [7:0]  qp_cfg_psn = '0;
  logic        qp_cfg_active = 1'b0;
  logic        mr_cfg_we = 1'b0;
  logic [1:0]  mr_cfg_idx = '0;
  logic [31:0] mr_cfg_base = '0;
  logic [15:0] mr_cfg_len = '0;
  logic [15:0] mr_cfg_key = '0;
  logic        mr_cfg_rd = 1'b0;
  logic        mr_cfg_wr = 1'b0;
  logic        mr_cfg_valid = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_op = 1'b0;
  logic [7:0]  req_qpn = '0;
  logic [7:0]  req_psn = '0;
  logic [31:0] req_vaddr = '0;
  logic [15:0] req_rkey = '0;
  logic [15:0] req_len = '0;
  logic        dec_valid;
  logic        dec_ready = 1'b1;
  logic        dec_grant;
  logic [2:0]  dec_reason;
  logic        dec_op;
  logic [31:0] dec_vaddr;
  logic [15:0] dec_len;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic        g;
    logic [2:0]  r;
    logic        op;
    logic [31:0] va;
    logic [15:0] len;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  rma_req_checker u0 (.*);

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cfg_qp(int idx, int qpn, int psn, bit act);
    qp_cfg_we = 1'b1; qp_cfg_idx = 2'(idx); qp_cfg_qpn = 8'(qpn);
    qp_cfg_psn = 8'(psn); qp_cfg_active = act;
    tick();
    qp_cfg_we = 1'b0;
  endtask

  task automatic cfg_mr(int idx, logic [31:0] base, int len, int key, bit rd, bit wr, bit vld);
    mr_cfg_we = 1'b1; mr_cfg_idx = 2'(idx); mr_cfg_base = base;
    mr_cfg_len = 16'(len); mr_cfg_key = 16'(key);
    mr_cfg_rd = rd; mr_cfg_wr = wr; mr_cfg_valid = vld;
    tick();
    mr_cfg_we = 1'b0;
  endtask

  // driver: queue the expectation, then present the request until taken
  task automatic send(bit op, int qpn, int psn, logic [31:0] va, int key, int len,
                      bit g, int r, string tag);
    exp_t e;
    bit acc;
    e.g = g; e.r = 3'(r); e.op = op; e.va = va; e.len = 16'(len); e.tag = tag;
    sb.push_back(e);
    req_op = op; req_qpn = 8'(qpn); req_psn = 8'(psn); req_vaddr = va;
    req_rkey = 16'(key); req_len = 16'(len); req_valid = 1'b1;
    do begin
      @(negedge clk);
      acc = req_ready;
      tick();
    end while (!acc);
    req_valid = 1'b0;
  endtask

  // monitor: compare each decision in the cycle it transfers
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && dec_valid && dec_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2", "unexpected decision", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(dec_grant == e.g, e.tag, "grant", dec_grant, e.g);
          check(dec_reason == e.r, e.tag, "reason", dec_reason, e.r);
          if (e.g) begin
            check(dec_vaddr == e.va && dec_len == e.len && dec_op == e.op, "R10",
                  "granted addr", dec_vaddr, e.va);
          end
        end
      end
    end
  end

  task automatic drain();
    while (sb.size() != 0) tick();
    tick();
  endtask

  initial begin
    repeat (3) tick();
    check(dec_valid == 1'b0, "R1", "dec_valid after reset", dec_valid, 0);
    rst_n = 1'b1;
    tick();
    check(dec_valid == 1'b0, "R1", "dec_valid idle", dec_valid, 0);
    check(req_ready == 1'b1, "R1", "req_ready idle", req_ready, 1);
    send(1, 5, 10, 32'h1000, 'hA1, 8, 0, 1, "R1");
    drain();

    cfg_qp(0, 5, 10, 1);
    cfg_qp(1, 9, 200, 1);
    cfg_mr(0, 32'h0000_1000, 'h100, 'hA1, 1, 1, 1);
    cfg_mr(1, 32'h0000_2000, 'h80, 'hB2, 1, 0, 1);
    cfg_mr(2, 32'hFFFF_FF00, 'h100, 'hC3, 1, 1, 1);

    send(0, 5, 10, 32'h1000, 'hA1, 'h100, 1, 0, "R6");  // exact fill
    send(1, 5, 11, 32'h1010, 'hA1, 'h10, 1, 0, "R10");
    send(1, 7, 12, 32'h1010, 'hA1, 'h10, 0, 1, "R3");
    send(1, 5, 20, 32'h1010, 'hA1, 'h10, 0, 2, "R4");
    send(1, 5, 12, 32'h1010, 'h55, 'h10, 0, 3, "R5");
    send(1, 5, 12, 32'h1001, 'hA1, 'h100, 0, 4, "R6");
    send(1, 5, 12, 32'h0FFF, 'hA1, 1, 0, 4, "R6");
    send(1, 5, 12, 32'hFFFF_FFF0, 'hC3, 'h20, 0, 4, "R7");
    send(0, 5, 12, 32'hFFFF_FFF0, 'hC3, 'h10, 1, 0, "R7");
    send(0, 5, 13, 32'h2000, 'hB2, 4, 0, 5, "R8");
    send(1, 5, 13, 32'h2000, 'hB2, 'h80, 1, 0, "R8");
    send(1, 7, 99, 32'h9000, 'h55, 4, 0, 1, "R9");
    send(1, 5, 99, 32'h9000, 'h55, 4, 0, 2, "R9");
    send(1, 5, 14, 32'h9000, 'h55, 4, 0, 3, "R9");
    send(0, 5, 14, 32'h2100, 'hB2, 4, 0, 4, "R9");
    send(1, 9, 200, 32'h1000, 'hA1, 8, 1, 0, "R4");
    send(1, 5, 14, 32'h1000, 'hA1, 8, 1, 0, "R4");
    drain();

    cfg_qp(1, 9, 255, 1);
    send(1, 9, 255, 32'h1000, 'hA1, 8, 1, 0, "R4");
    send(1, 9, 0, 32'h1000, 'hA1, 8, 1, 0, "R4");
    send(1, 9, 255, 32'h1000, 'hA1, 8, 0, 2, "R4");
    drain();

    cfg_mr(0, 32'h0000_1000, 'h100, 'hA1, 1, 1, 0);
    send(1, 5, 15, 32'h1000, 'hA1, 8, 0, 3, "R11");
    drain();
    cfg_qp(0, 5, 15, 0);
    send(1, 5, 15, 32'h2000, 'hB2, 8, 0, 1, "R3");
    drain();

    // back-pressure
    dec_ready = 1'b0;
    send(1, 7, 0, 32'h2000, 'hB2, 8, 0, 1, "R2");
    check(dec_valid == 1'b1, "R2", "decision one cycle after accept", dec_valid, 1);
    check(req_ready == 1'b0, "R2", "req_ready while stalled", req_ready, 0);
    for (int k = 0; k < 3; k++) begin
      tick();
      check(dec_valid == 1'b1 && dec_reason == 3'd1, "R2", "held decision", dec_reason, 1);
      check(req_ready == 1'b0, "R2", "req_ready still low", req_ready, 0);
    end
    dec_ready = 1'b1;
    drain();
    check(dec_valid == 1'b0, "R2", "drained", dec_valid, 0);
    check(sb.size() == 0, "R2", "pending expectations", sb.size(), 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      check(1'b0, "R2", "watchdog expired", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule